// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block is a serial-bus slave that presents a 512-byte EEPROM to an SPI master. The master frames each command with an active-low select. It clocks one opcode byte, then optional address and data bytes, MSB first. The storage is a register array inside the block. Bus pins are brought into the system clock domain through two-stage synchronizers, and SCK edges are detected there. The system clock must therefore run several times faster than SCK.

Six opcodes are decoded:

| Opcode | Action |
|---|---|
| 0x06 | Set the write-enable latch |
| 0x04 | Clear the write-enable latch |
| 0x05 | Read the status byte |
| 0x01 | Write the status byte |
| 0x03 | Read data |
| 0x02 | Write data |

For data access, bit 3 of the opcode supplies address bit 8.

Write data is gathered in a page buffer and committed when select is released. This starts a programming interval that lasts a parameterized number of clock cycles. During it the device reports itself busy and honours only status reads.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset, MISO is 0 and a status read (opcode 0x05) returns 0x00.
- R2: Bits are sampled on rising SCK and MISO changes only after falling SCK, MSB first, with SCK idling either low or high (modes 0,0 and 1,1); MISO is 0 while select is inactive.
- R3: Opcode 0x06 sets and opcode 0x04 clears the write-enable latch; status bit 1 shows the latch.
- R4: Opcode 0x05 returns the status byte {stored bits 7:2, latch, busy} in every following byte of the frame.
- R5: Read (0x03, bit 3 = address bit 8, next byte = address bits 7:0) returns bytes from consecutive addresses, wrapping from 0x1FF to 0x000.
- R6: Write (0x02, same address encoding) stores each data byte at the current address and increments only address bits 3:0, so data wraps inside its 16-byte page.
- R7: Write and write-status (0x01) have no effect and start no programming unless the latch was set in an earlier frame.
- R8: Data is committed when select is released; a partial last byte is discarded, and a write frame with no complete data byte starts no programming.
- R9: Committing starts a programming interval of PROG_CYCLES clocks with status bit 0 at 1; at its end bit 0 returns to 0 and the latch clears.
- R10: While busy, every opcode except 0x05 is ignored: latch opcodes do not act, and a read returns 0x00 bytes.
- R11: Write-status stores bits 7:2 of its data byte, which then read back in status bits 7:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from the master |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data into the slave |
| miso | output | 1 | Serial data out of the slave |

## Verification
The bound checker watches every cycle for these rules:
- the programming interval starts only on a select release with the latch set;
- the interval never outlasts its configured length;
- the latch is clear when busy falls;
- the latch never rises while busy;
- the stored status bits change only while the latch was set;
- MISO moves only after a falling SCK edge or a select change.

Data integrity can be shown only by the bench's scenarios, run in both SCK idle levels against a byte model of the array. These cover:
- page wrap of writes and address wrap of reads;
- discarded partial bytes;
- ignored commands while busy;
- the unchanged contents after a write without the latch.

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int PAGE_W      = 4,
  parameter int PROG_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  localparam int ADDR_W = 9;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE   = 1 << PAGE_W;
  localparam int CW     = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {C_NONE, C_READ, C_WRITE, C_RDSR, C_WRSR} cmd_t;

  logic [2:0] cs_s, sck_s;
  logic [1:0] mosi_s;
  logic [2:0] bitcnt;
  logic [1:0] bytecnt;
  logic [6:0] shreg;
  cmd_t       cmd;
  logic       opb3;
  logic [ADDR_W-1:0] addr;
  logic [7:0] tx;
  logic       miso_q, wel, busy, wrsr_has;
  logic [CW-1:0] pcnt;
  logic [5:0] stat_hi, wrsr_val;
  logic [PAGE-1:0] pmask;
  logic [7:0] pbuf [PAGE];
  logic [7:0] mem  [DEPTH];

  wire cs_fall_evt = cs_s[2] & ~cs_s[1];
  wire cs_rise_evt = ~cs_s[2] & cs_s[1];
  wire in_frame    = ~cs_s[2] & ~cs_s[1];
  wire sck_rise    = in_frame & ~sck_s[2] & sck_s[1];
  wire sck_fall    = in_frame & sck_s[2] & ~sck_s[1];
  wire [7:0] rx_byte = {shreg, mosi_s[1]};
  wire byte_done   = sck_rise & (bitcnt == 3'd7);
  wire [7:0] status = {stat_hi, wel, busy};
  wire [ADDR_W-1:0] addr_ld = {opb3, rx_byte};
  wire [ADDR_W-1:0] rd_addr = (bytecnt == 2'd1) ? addr_ld : addr;
  wire commit   = cs_rise_evt & (cmd == C_WRITE) & (|pmask);
  wire stcommit = cs_rise_evt & (cmd == C_WRSR) & wrsr_has;

  assign miso = in_frame & miso_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_s <= 3'b111; sck_s <= 3'b000; mosi_s <= 2'b00;
    end else begin
      cs_s <= {cs_s[1:0], cs_n}; sck_s <= {sck_s[1:0], sck}; mosi_s <= {mosi_s[0], mosi};
    end

  always_ff @(posedge clk) begin
    if (byte_done && cmd == C_WRITE && bytecnt == 2'd2)
      pbuf[addr[PAGE_W-1:0]] <= rx_byte;
    for (int i = 0; i < PAGE; i++)
      if (commit && pmask[i]) mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitcnt <= '0; bytecnt <= '0; shreg <= '0; cmd <= C_NONE; opb3 <= 1'b0;
      addr <= '0; tx <= '0; miso_q <= 1'b0; wel <= 1'b0; busy <= 1'b0;
      wrsr_has <= 1'b0; pcnt <= '0; stat_hi <= '0; wrsr_val <= '0; pmask <= '0;
    end else begin
      if (cs_fall_evt) begin
        bitcnt <= '0; bytecnt <= '0; cmd <= C_NONE; tx <= '0;
        miso_q <= 1'b0; pmask <= '0; wrsr_has <= 1'b0;
      end else if (in_frame) begin
        if (sck_rise) begin
          shreg  <= rx_byte[6:0];
          bitcnt <= bitcnt + 3'd1;
        end
        if (byte_done) begin
          if (bytecnt != 2'd2) bytecnt <= bytecnt + 2'd1;
          if (bytecnt == 2'd0) begin
            cmd <= C_NONE; opb3 <= rx_byte[3]; tx <= '0;
            if (rx_byte == 8'h05) begin
              cmd <= C_RDSR; tx <= status;
            end else if (!busy) begin
              if (rx_byte == 8'h06) wel <= 1'b1;
              if (rx_byte == 8'h04) wel <= 1'b0;
              if ((rx_byte & 8'hF7) == 8'h03) cmd <= C_READ;
              if ((rx_byte & 8'hF7) == 8'h02 && wel) cmd <= C_WRITE;
              if (rx_byte == 8'h01 && wel) cmd <= C_WRSR;
            end
          end else begin
            case (cmd)
              C_RDSR: tx <= status;
              C_READ: begin
                tx   <= mem[rd_addr];
                addr <= rd_addr + 1'b1;
              end
              C_WRITE:
                if (bytecnt == 2'd1) addr <= addr_ld;
                else begin
                  pmask[addr[PAGE_W-1:0]] <= 1'b1;
                  addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
                end
              C_WRSR:
                if (bytecnt == 2'd1) begin
                  wrsr_val <= rx_byte[7:2]; wrsr_has <= 1'b1;
                end
              default: ;
            endcase
          end
        end
        if (sck_fall) miso_q <= tx[~bitcnt];
      end
      if (stcommit) stat_hi <= wrsr_val;
      if (commit || stcommit) begin
        busy <= 1'b1;
        pcnt <= CW'(PROG_CYCLES - 1);
      end else if (busy) begin
        if (pcnt == '0) begin
          busy <= 1'b0; wel <= 1'b0;
        end else pcnt <= pcnt - 1'b1;
      end
    end
endmodule

// File: rtl/spi_eeprom_chk.sv
module spi_eeprom_chk #(
  parameter int PROG_CYCLES = 4000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       wel,
  input logic [5:0] stat_hi,
  input logic       sck_fall,
  input logic       in_frame,
  input logic       miso,
  input logic       cs_rise
);
  int unsigned busy_len;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) busy_len <= 0;
    else busy_len <= busy ? busy_len + 1 : 0;

  // R7 R8
  prog_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cs_rise) && $past(wel)));
  // R9
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  // R9
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= PROG_CYCLES);
  // R10
  wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(busy));
  // R11
  stat_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_hi) |-> $past(wel));
  // R2
  miso_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> ($past(sck_fall) || !$stable(in_frame)));
endmodule

bind spi_eeprom_slave spi_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel), .stat_hi(stat_hi),
  .sck_fall(sck_fall), .in_frame(in_frame), .miso(miso), .cs_rise(cs_rise_evt));

// File: tb/tb_spi_eeprom_slave.sv
module tb_spi_eeprom_slave;
  localparam int HALF = 8;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso;
  logic cpol = 1'b0;
  int total = 0, bad = 0;
  logic [7:0] model [512];
  logic [5:0] exp_hi = '0;

  always #2 clk = ~clk;

  spi_eeprom_slave #(.PAGE_W(4), .PROG_CYCLES(1500)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso));

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic bits(input logic [7:0] o, input int n, output logic [7:0] i);
    i = '0;
    for (int b = 7; b > 7 - n; b--) begin
      if (cpol) sck = 1'b0;
      mosi = o[b];
      repeat (HALF) @(negedge clk);
      i[b] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      if (!cpol) sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] o, output logic [7:0] i);
    bits(o, 8, i);
  endtask

  task automatic sel();
    cs_n = 1'b0; repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk); cs_n = 1'b1; repeat (HALF) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    sel(); xfer(op, d); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    sel(); xfer(8'h05, d); xfer(8'hFF, s); desel();
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    for (int k = 0; k < 60; k++) begin
      rdsr(s);
      if (!s[0]) break;
    end
  endtask

  task automatic wr(input logic [8:0] a, input int n, input logic [7:0] base,
                    input logic [7:0] step, input int extra, input bit en);
    logic [7:0] d;
    if (en) cmd1(8'h06);
    sel();
    xfer(8'h02 | {4'b0, a[8], 3'b0}, d);
    xfer(a[7:0], d);
    for (int i = 0; i < n; i++) begin
      xfer(base + 8'(i) * step, d);
      if (en) model[{a[8:4], 4'(a[3:0] + 4'(i))}] = base + 8'(i) * step;
    end
    if (extra > 0) bits(8'hA5, extra, d);
    desel();
  endtask

  task automatic rd(input logic [8:0] a, input int n, input string tag);
    logic [7:0] d;
    sel();
    xfer(8'h03 | {4'b0, a[8], 3'b0}, d);
    xfer(a[7:0], d);
    for (int i = 0; i < n; i++) begin
      xfer(8'hFF, d);
      check(tag, d, model[9'(a + 9'(i))]);
    end
    desel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] s, d, d2;
    repeat (5) @(negedge clk);
    check("R1 miso after reset", {7'b0, miso}, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 miso idle", {7'b0, miso}, 8'h00);
    rdsr(s); check("R1 status after reset", s, 8'h00);

    for (int m = 0; m < 2; m++) begin
      cpol = m[0]; sck = cpol; repeat (10) @(negedge clk);
      // R3
      cmd1(8'h06); rdsr(s); check("R3 latch set", s, {exp_hi, 2'b10});
      cmd1(8'h04); rdsr(s); check("R3 latch clear", s, {exp_hi, 2'b00});
      // R9 R10
      wr(9'h1F0, 16, 8'h10 + 8'(m) * 8'h40, 8'd3, 0, 1'b1);
      rdsr(s); check("R9 busy with latch", s, {exp_hi, 2'b11});
      sel(); xfer(8'h0B, d); xfer(8'hF0, d); xfer(8'hFF, d); desel();
      check("R10 read while busy", d, 8'h00);
      cmd1(8'h06);
      wait_ready();
      rdsr(s); check("R9 R10 idle and latch cleared", s, {exp_hi, 2'b00});
      wr(9'h000, 16, 8'h80 + 8'(m), 8'd5, 0, 1'b1); wait_ready();
      rd(9'h1F0, 16, "R6 page data");
      rd(9'h1FE, 4, "R5 read wrap");
      // R6 page wrap
      wr(9'h100, 16, 8'h20, 8'd1, 0, 1'b1); wait_ready();
      wr(9'h10A, 14, 8'hC0 + 8'(m), 8'd2, 0, 1'b1); wait_ready();
      rd(9'h100, 16, "R6 write wrap");
      // R7
      wr(9'h005, 3, 8'h33, 8'd1, 0, 1'b0);
      rdsr(s); check("R7 no programming", s, {exp_hi, 2'b00});
      rd(9'h000, 8, "R7 array unchanged");
      // R8
      wr(9'h020, 16, 8'h50, 8'd7, 0, 1'b1); wait_ready();
      wr(9'h024, 2, 8'hE0, 8'd1, 5, 1'b1); wait_ready();
      rd(9'h020, 8, "R8 partial discard");
      cmd1(8'h06); sel(); xfer(8'h02, d); xfer(8'h30, d); desel();
      rdsr(s); check("R8 address only", s, {exp_hi, 2'b10});
      cmd1(8'h04);
      // R11
      cmd1(8'h06); sel(); xfer(8'h01, d); xfer(8'h8C ^ (8'(m) * 8'h30), d); desel();
      exp_hi = 6'((8'h8C ^ (8'(m) * 8'h30)) >> 2);
      rdsr(s); check("R11 busy after status write", s, {exp_hi, 2'b11});
      wait_ready();
      rdsr(s); check("R11 status stored", s, {exp_hi, 2'b00});
      sel(); xfer(8'h01, d); xfer(8'h54, d); desel();
      rdsr(s); check("R7 status write ignored", s, {exp_hi, 2'b00});
      // R4
      sel(); xfer(8'h05, d); xfer(8'hFF, d); xfer(8'hFF, d2); desel();
      check("R4 status first", d, {exp_hi, 2'b00});
      check("R4 status repeat", d2, {exp_hi, 2'b00});
      check("R2 miso deselected", {7'b0, miso}, 8'h00);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule